// File: doc/BRIEF.md
# Dual-Bank Pointer Address Generator

This block forms the addresses for indirect writes into the two data RAM banks of a small DSP. It keeps eight pointer registers, split into two groups of four. The first group addresses RAM bank 0 and the second group addresses RAM bank 1. Each write request carries a 5-bit selector. The selector names a bank, a pointer within that bank and a post-access modifier. The block writes the data word at the chosen address, updates the pointer when the modifier asks for it, and reports on registered outputs the bank and address it used.

The last pointer position in each group is not a real register. It reads as zero and ignores loads. When a write request names it, the modifier value itself is the address, so modifiers 0 to 3 reach cells 0 to 3 at the start of the bank. Pointers can also be loaded directly. A registered read port on each side lets the surrounding logic see pointer values and RAM contents.

Top module: `dbp_agu`

## Requirements
- R1: The selector `wr_sel` decodes as follows: bits [1:0] are the pointer index, bit [2] is the bank (0 = bank 0 with pointers 0-3, 1 = bank 1 with pointers 4-7), and bits [4:3] are the modifier. The pointer number is {bank, index}. One cycle after a request with `wr_en` high, `acc_strobe` is high and `acc_bank` equals the selector's bank bit. In any other cycle after reset, `acc_strobe` is low.
- R2: Modifier 00 on index 0-2 writes at the pointer's current value and leaves the pointer unchanged.
- R3: Modifier 01 on index 0-2 writes at the pointer's current value and then adds one to the pointer.
- R4: Modifier 10 on index 0-2 writes at the pointer's current value and then subtracts one from the pointer.
- R5: Modifier 11 on index 0-2 behaves exactly like modifier 01.
- R6: For index 3, the write address is the modifier value (cells 0, 1, 2 or 3 of the selected bank), and no pointer changes.
- R7: Pointers 3 and 7 always read zero. Direct loads to them have no effect.
- R8: Pointers are 8 bits wide. Incrementing 0xFF gives 0x00, and decrementing 0x00 gives 0xFF.
- R9: A direct load (`ld_en`, `ld_idx`, `ld_val`) takes effect on the clock edge. If it targets the same pointer that a write updates in that cycle, the loaded value wins. The write still uses the pointer's value from before the edge.
- R10: Reset clears all pointers, both RAM banks, `acc_strobe`, `acc_bank` and `acc_addr`.
- R11: The write data lands only in the addressed cell of the selected bank. The read port returns `mem[rd_bank][rd_addr]` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Indirect write request |
| wr_sel | input | 5 | Modifier [4:3], bank [2], pointer index [1:0] |
| wr_data | input | 16 | Data word to write |
| ld_en | input | 1 | Direct pointer load enable |
| ld_idx | input | 3 | Pointer number to load |
| ld_val | input | 8 | Value to load |
| ptr_rd_idx | input | 3 | Pointer number to read back |
| rd_bank | input | 1 | RAM bank for the read port |
| rd_addr | input | 8 | RAM address for the read port |
| acc_strobe | output | 1 | A write was performed in the previous cycle |
| acc_bank | output | 1 | Bank of that write |
| acc_addr | output | 8 | Address of that write |
| ptr_rd_val | output | 8 | Registered pointer value |
| rd_data | output | 16 | Registered RAM read data |

## Verification
The pointer-update properties are written with one assumption: a direct load does not target the pointer being updated. Those properties apply only in cycles where the load and the write name different pointers. The load-wins case (R9) has its own property. The properties also assume that the selector is stable in the sampling cycle, which holds because the stimulus changes inputs only on the falling edge. The bench keeps RAM reads apart from writes to the same cell, so the read-during-write ordering is never relied on.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

  // Post-access behaviour named by selector bits [4:3]
  typedef enum logic [1:0] {
    MOD_HOLD = 2'd0,
    MOD_INC  = 2'd1,
    MOD_DEC  = 2'd2,
    MOD_INC2 = 2'd3
  } mod_e;

  // Field layout of the write selector (MSB first)
  typedef struct packed {
    mod_e       mode;
    logic       bank;
    logic [1:0] idx;
  } sel_t;

  localparam int SEL_W      = 5;
  localparam int IDX_W      = 2;
  localparam int PER_BANK   = 4;
  localparam int NUM_BANKS  = 2;
  localparam int NUM_PTRS   = PER_BANK * NUM_BANKS;
  localparam int SLOT_W     = $clog2(NUM_PTRS);

endpackage

// File: rtl/dbp_sel_decode.sv
module dbp_sel_decode
  import dbp_pkg::*;
#(
  parameter int PW = 8
) (
  input  sel_t          sel,
  input  logic [PW-1:0] cur_ptr,
  output logic          fixed_cell,
  output logic [PW-1:0] addr,
  output logic          upd_en,
  output logic          upd_dec
);

  localparam int PAD = PW - IDX_W;

  always_comb begin
    fixed_cell = (sel.idx == {IDX_W{1'b1}});
    // Fixed slot: the modifier code is the cell number at the bank base
    addr       = fixed_cell ? {{PAD{1'b0}}, sel.mode} : cur_ptr;
    upd_en     = !fixed_cell && (sel.mode != MOD_HOLD);
    upd_dec    = (sel.mode == MOD_DEC);
  end

endmodule

// File: rtl/dbp_ptr_file.sv
module dbp_ptr_file #(
  parameter int PW     = 8,
  parameter int NPTR   = 8,
  parameter int GROUP  = 4,
  parameter int SLOT_W = $clog2(NPTR)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_en,
  input  logic [SLOT_W-1:0]         upd_slot,
  input  logic                      upd_dec,
  input  logic                      ld_en,
  input  logic [SLOT_W-1:0]         ld_slot,
  input  logic [PW-1:0]             ld_val,
  output logic [NPTR-1:0][PW-1:0]   ptrs
);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    if ((g % GROUP) == GROUP - 1) begin : g_fixed
      // Bank base slot: hard-wired to cell zero
      assign ptrs[g] = '0;
    end else begin : g_live
      logic [PW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (ld_en && ld_slot == SLOT_W'(g)) begin
          q <= ld_val;
        end else if (upd_en && upd_slot == SLOT_W'(g)) begin
          q <= upd_dec ? q - 1'b1 : q + 1'b1;
        end
      end
      assign ptrs[g] = q;
    end
  end

endmodule

// File: rtl/dbp_ram_bank.sv
module dbp_ram_bank #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/dbp_agu.sv
module dbp_agu
  import dbp_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [4:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_en,
  input  logic [2:0]        ld_idx,
  input  logic [PTR_W-1:0]  ld_val,
  input  logic [2:0]        ptr_rd_idx,
  input  logic              rd_bank,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic              acc_strobe,
  output logic              acc_bank,
  output logic [PTR_W-1:0]  acc_addr,
  output logic [PTR_W-1:0]  ptr_rd_val,
  output logic [DATA_W-1:0] rd_data
);

  sel_t                           sel;
  logic [SLOT_W-1:0]              slot;
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_all;
  logic                           fixed_cell;
  logic [PTR_W-1:0]               wr_addr;
  logic                           upd_en, upd_dec;
  logic [DATA_W-1:0]              bank_rdata [NUM_BANKS];
  logic                           rd_bank_q;

  assign sel  = sel_t'(wr_sel);
  assign slot = {sel.bank, sel.idx};

  dbp_sel_decode #(.PW(PTR_W)) u_dec (
    .sel       (sel),
    .cur_ptr   (ptr_all[slot]),
    .fixed_cell(fixed_cell),
    .addr      (wr_addr),
    .upd_en    (upd_en),
    .upd_dec   (upd_dec)
  );

  dbp_ptr_file #(
    .PW    (PTR_W),
    .NPTR  (NUM_PTRS),
    .GROUP (PER_BANK),
    .SLOT_W(SLOT_W)
  ) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (wr_en && upd_en),
    .upd_slot(slot),
    .upd_dec (upd_dec),
    .ld_en   (ld_en),
    .ld_slot (ld_idx),
    .ld_val  (ld_val),
    .ptrs    (ptr_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dbp_ram_bank #(.DW(DATA_W), .AW(PTR_W)) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && (sel.bank == 1'(b))),
      .waddr(wr_addr),
      .wdata(wr_data),
      .raddr(rd_addr),
      .rdata(bank_rdata[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_strobe <= 1'b0;
      acc_bank   <= 1'b0;
      acc_addr   <= '0;
      ptr_rd_val <= '0;
      rd_bank_q  <= 1'b0;
    end else begin
      acc_strobe <= wr_en;
      if (wr_en) begin
        acc_bank <= sel.bank;
        acc_addr <= wr_addr;
      end
      ptr_rd_val <= ptr_all[ptr_rd_idx];
      rd_bank_q  <= rd_bank;
    end
  end

  assign rd_data = bank_rdata[rd_bank_q];

  // fixed_cell is consumed inside the decoder's address choice; kept visible
  // for the checker through the pointer array instead.
  logic unused_fixed;
  assign unused_fixed = fixed_cell;

endmodule

// File: rtl/dbp_agu_chk.sv
module dbp_agu_chk #(
  parameter int PW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [4:0]           wr_sel,
  input logic                 ld_en,
  input logic [2:0]           ld_idx,
  input logic [PW-1:0]        ld_val,
  input logic                 acc_strobe,
  input logic                 acc_bank,
  input logic [PW-1:0]        acc_addr,
  input logic [7:0][PW-1:0]   ptr_all
);

  logic no_ld_clash;
  assign no_ld_clash = !(ld_en && ld_idx == wr_sel[2:0]);

  a_r1_strobe_on: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> acc_strobe);
  a_r1_strobe_off: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !acc_strobe);
  a_r1_bank: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> acc_bank == $past(wr_sel[2]));
  a_r1_ptr_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[1:0] != 2'd3) |=> acc_addr == $past(ptr_all[wr_sel[2:0]]));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[4:3] == 2'd0 && no_ld_clash)
      |=> ptr_all[$past(wr_sel[2:0])] == $past(ptr_all[wr_sel[2:0]]));
  a_r3_inc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[4:3] == 2'd1 && wr_sel[1:0] != 2'd3 && no_ld_clash)
      |=> ptr_all[$past(wr_sel[2:0])] == $past(ptr_all[wr_sel[2:0]]) + 8'd1);
  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[4:3] == 2'd2 && wr_sel[1:0] != 2'd3 && no_ld_clash)
      |=> ptr_all[$past(wr_sel[2:0])] == $past(ptr_all[wr_sel[2:0]]) - 8'd1);
  a_r5_inc_alt: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[4:3] == 2'd3 && wr_sel[1:0] != 2'd3 && no_ld_clash)
      |=> ptr_all[$past(wr_sel[2:0])] == $past(ptr_all[wr_sel[2:0]]) + 8'd1);
  a_r6_fixed_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel[1:0] == 2'd3)
      |=> acc_addr == {{(PW-2){1'b0}}, $past(wr_sel[4:3])});
  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_idx[1:0] != 2'd3) |=> ptr_all[$past(ld_idx)] == $past(ld_val));

endmodule

bind dbp_agu dbp_agu_chk #(.PW(PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .ld_val    (ld_val),
  .acc_strobe(acc_strobe),
  .acc_bank  (acc_bank),
  .acc_addr  (acc_addr),
  .ptr_all   (ptr_all)
);

// File: tb/dbp_agu_tb.sv
module dbp_agu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [7:0]  ld_val = '0;
  logic [2:0]  ptr_rd_idx = '0;
  logic        rd_bank = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        acc_strobe, acc_bank;
  logic [7:0]  acc_addr, ptr_rd_val;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  dbp_agu u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val), .ptr_rd_idx(ptr_rd_idx),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .acc_strobe(acc_strobe),
    .acc_bank(acc_bank), .acc_addr(acc_addr), .ptr_rd_val(ptr_rd_val),
    .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [8:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] m_ptr [8];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: each strobe pops one expected {bank, addr}
  always @(negedge clk) begin
    if (!rst && acc_strobe) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected strobe", 32'(acc_strobe), 32'd0);
      end else begin
        automatic logic [8:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check({t, " bank/addr"}, {23'd0, acc_bank, acc_addr}, {23'd0, e});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_ptr[i] = '0;
  endtask

  // Driver: one write (optionally with a load), expected result pushed
  task automatic do_write(string tag, logic [4:0] sel, logic [15:0] d,
                          logic with_ld = 1'b0, logic [2:0] li = 3'd0,
                          logic [7:0] lv = 8'd0);
    automatic logic [2:0] slot = sel[2:0];
    automatic logic [1:0] mode = sel[4:3];
    automatic logic [7:0] ea;
    @(negedge clk);
    ea = (sel[1:0] == 2'd3) ? {6'd0, mode} : m_ptr[slot];
    exp_q.push_back({sel[2], ea});
    tag_q.push_back(tag);
    if (sel[1:0] != 2'd3 && mode == 2'd2) m_ptr[slot] = m_ptr[slot] - 8'd1;
    else if (sel[1:0] != 2'd3 && mode != 2'd0) m_ptr[slot] = m_ptr[slot] + 8'd1;
    if (with_ld && li[1:0] != 2'd3) m_ptr[li] = lv;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    ld_en = with_ld; ld_idx = li; ld_val = lv;
    @(negedge clk);
    wr_en = 1'b0; ld_en = 1'b0;
  endtask

  task automatic do_load(logic [2:0] li, logic [7:0] lv);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = li; ld_val = lv;
    if (li[1:0] != 2'd3) m_ptr[li] = lv;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic chk_ptr(string tag, logic [2:0] i, logic [7:0] exp);
    @(negedge clk);
    ptr_rd_idx = i;
    @(negedge clk);
    check(tag, 32'(ptr_rd_val), 32'(exp));
  endtask

  task automatic chk_ram(string tag, logic b, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    rd_bank = b; rd_addr = a;
    @(negedge clk);
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 strobe after reset", 32'(acc_strobe), 32'd0);
    check("R10 addr after reset", 32'(acc_addr), 32'd0);
    for (int i = 0; i < 8; i++) chk_ptr("R10 pointer cleared", 3'(i), 8'd0);
    chk_ram("R10 ram0 cleared", 1'b0, 8'd0, 16'd0);

    // Direct loads; R7 load to fixed slot ignored
    do_load(3'd0, 8'h10);
    do_load(3'd1, 8'hFF);
    do_load(3'd5, 8'h20);
    do_load(3'd3, 8'h55);
    do_load(3'd7, 8'hAA);
    chk_ptr("R7 ptr3 ignores load", 3'd3, 8'd0);
    chk_ptr("R7 ptr7 ignores load", 3'd7, 8'd0);
    chk_ptr("R9 direct load", 3'd5, 8'h20);

    do_write("R3", 5'b01_0_00, 16'h1111);        // r0 +
    chk_ptr("R3 increment", 3'd0, 8'h11);
    do_write("R8", 5'b01_0_01, 16'h2222);        // r1 0xFF +
    chk_ptr("R8 wrap up", 3'd1, 8'h00);
    do_write("R4", 5'b10_1_01, 16'h3333);        // r5 -
    chk_ptr("R4 decrement", 3'd5, 8'h1F);
    do_write("R8", 5'b10_0_10, 16'h4444);        // r2 0 -
    chk_ptr("R8 wrap down", 3'd2, 8'hFF);
    do_write("R5", 5'b11_1_01, 16'h5555);        // r5 + via 11
    chk_ptr("R5 alt increment", 3'd5, 8'h20);
    do_write("R2", 5'b00_0_00, 16'h6666);        // r0 hold
    chk_ptr("R2 hold", 3'd0, 8'h11);

    // R6 fixed cells, bank 0 then bank 1
    do_write("R6", 5'b00_0_11, 16'hA000);
    do_write("R6", 5'b01_0_11, 16'hA001);
    do_write("R6", 5'b10_0_11, 16'hA002);
    do_write("R6", 5'b11_0_11, 16'hA003);
    do_write("R6", 5'b10_1_11, 16'hB002);
    chk_ptr("R6 ptr3 unchanged", 3'd3, 8'd0);
    chk_ptr("R6 ptr7 unchanged", 3'd7, 8'd0);
    chk_ptr("R6 ptr0 unchanged", 3'd0, 8'h11);

    // R9 load collides with update on r0; write uses old value
    do_write("R9", 5'b01_0_00, 16'h7777, 1'b1, 3'd0, 8'h40);
    chk_ptr("R9 load wins", 3'd0, 8'h40);
    // load to another pointer alongside an update: both apply
    do_write("R9", 5'b01_0_01, 16'h8888, 1'b1, 3'd4, 8'h33);
    chk_ptr("R9 other update", 3'd1, 8'h01);
    chk_ptr("R9 other load", 3'd4, 8'h33);

    // R11 data placement
    chk_ram("R11 bank0 cell 0x10", 1'b0, 8'h10, 16'h1111);
    chk_ram("R11 bank0 cell 0x11", 1'b0, 8'h11, 16'h7777);
    chk_ram("R11 bank1 cell 0x20", 1'b1, 8'h20, 16'h3333);
    chk_ram("R11 bank1 cell 0x10 untouched", 1'b1, 8'h10, 16'h0000);
    chk_ram("R6 bank0 cell 3", 1'b0, 8'h03, 16'hA003);
    chk_ram("R6 bank1 cell 2", 1'b1, 8'h02, 16'hB002);
    chk_ram("R6 bank1 cell 3 untouched", 1'b1, 8'h03, 16'h0000);

    repeat (2) @(negedge clk);
    check("R1 all strobes seen", 32'(exp_q.size()), 32'd0);

    // R10 reset mid-run
    do_reset();
    chk_ptr("R10 pointer cleared again", 3'd5, 8'd0);
    chk_ram("R10 ram0 cleared again", 1'b0, 8'h10, 16'd0);
    chk_ram("R10 ram1 cleared again", 1'b1, 8'h20, 16'd0);

    finish_run();
  end

endmodule